// File: doc/BRIEF.md
# Exception Entry/Exit Phase Sequencer

This block follows, cycle by cycle, how a processor moves between thread code and exception handlers. An arbiter outside the block offers the most urgent pending exception as a request with a vector number and a priority value, where a smaller value means more urgent. The sequencer answers with the phase it is in, the vector whose handler is running, and how many handlers are nested. No memory is accessed and no register contents are held. Fixed-length counters time each phase, so the block shows how many cycles each transition costs.

When a handler finishes and an eligible exception is waiting, the sequencer makes a short direct switch to it. It does not restore the context and then save it again. A more urgent request preempts the running handler: the sequencer saves a new context and records the preempted vector on an internal stack, and returns to that vector when the preempting handler ends. A sleep-on-exit mode parks the block after the last handler. A later request then resumes straight into its handler. A software-set deferred request is served at the lowest priority, and only once nothing else is waiting.

The arbiter holds a request asserted until the phase and vector outputs show that it has been taken. The active vector output changes only when a handler starts.

Top module: `exc_seq`

## Requirements
- R1: After reset, phase is idle (encoding 0), depth is 0, the active vector is 0, and stack_busy and nest_ovf are low. Phase encodings: idle 0, save 1, handler 2, restore 3, chain 4, sleep 5.
- R2: A request taken in idle causes exactly ENTRY_CYC (12) cycles of phase 1, with stack_busy high. The next phase is handler, with active_vec equal to the request vector and depth 1.
- R3: If done arrives in the handler phase at depth 1 and nothing is pending, the block spends exactly EXIT_CYC (10) cycles in phase 3 with stack_busy high. It then goes to idle with depth 0.
- R4: If a request is eligible when done arrives, the block spends exactly CHAIN_CYC (6) cycles in phase 4 with stack_busy low. It then enters the handler for that vector, and depth does not change.
- R5: A request whose priority value is strictly smaller than the running handler's starts a new 12-cycle save. When the new handler starts, depth has risen by one. A request of equal or larger value has no effect.
- R6: When a nested handler finishes with nothing eligible, a 10-cycle restore follows. Depth then drops by one and active_vec returns to the vector that was preempted.
- R7: At done with depth above 1, a pending request counts as eligible only if its priority value is strictly smaller than the preempted handler's. Otherwise the block restores instead of chaining.
- R8: With sleep_on_exit high, the last handler's done with nothing pending moves the block to sleep (phase 5) with depth 0. A request in sleep enters the handler in the next cycle, with no save phase and depth 1.
- R9: A defer_set pulse does not change the phase. The deferred request is taken at the lowest priority (all-ones value) as vector DEFER_VEC (14). It is reached by chaining at the end of the last handler when no request is pending, or through a save from idle. It is served once per pulse.
- R10: done has no effect outside the handler phase. In particular it does not shorten a save or restore, and it does not leave idle.
- R11: A strictly more urgent request during a save replaces the target vector without restarting the 12-cycle count. A request that is not more urgent leaves the target unchanged.
- R12: A preemption attempt at depth MAX_NEST (8) is refused: the phase and depth stay unchanged and nest_ovf goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Arbiter offers an exception |
| req_vec | input | VEC_W | Vector of the offered exception |
| req_prio | input | PRIO_W | Priority value of the offered exception, smaller is more urgent |
| done | input | 1 | Handler-finished strobe |
| defer_set | input | 1 | Pends the deferred request |
| sleep_on_exit | input | 1 | Sleep instead of restoring after the last handler |
| phase_o | output | 3 | Current phase encoding |
| active_vec_o | output | VEC_W | Vector of the running handler |
| depth_o | output | DEPTH_W | Number of nested handlers |
| stack_busy_o | output | 1 | A context save or restore is in progress |
| nest_ovf_o | output | 1 | Sticky nesting-overflow flag |

## Verification
The hardest situation to reach is the overflow refusal. It needs eight handlers nested one inside another, each strictly more urgent than the one below, before a ninth request arrives. The stimulus builds this as a ladder of priority values that fall by one at each level. It measures each 12-cycle save on the way up and each 10-cycle restore on the way down, and it checks the returning vector at every level. The priority-gated choice between chaining and restoring is just as hard to reach. A less urgent request is kept pending during a nested handler, so that it is restored past first and only chained into at depth 1.

// File: rtl/xseq_pkg.sv
package xseq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_SAVE    = 3'd1,
    PH_HANDLER = 3'd2,
    PH_RESTORE = 3'd3,
    PH_CHAIN   = 3'd4,
    PH_SLEEP   = 3'd5
  } xphase_e;

  // True when candidate priority value is strictly more urgent than current.
  function automatic logic outranks(input logic [7:0] cand, input logic [7:0] cur);
    return cand < cur;
  endfunction

  // Counter preload for a phase lasting the given number of cycles.
  function automatic int unsigned span_load(input int unsigned cycles);
    return (cycles > 0) ? cycles - 1 : 0;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/xseq_timer.sv
module xseq_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load)       cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R11
  count_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

endmodule

// File: rtl/xseq_ctx_stack.sv
module xseq_ctx_stack #(
  parameter int VEC_W  = 6,
  parameter int PRIO_W = 4,
  parameter int SLOTS  = 8,
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VEC_W-1:0]  wr_vec,
  input  logic [PRIO_W-1:0] wr_prio,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [VEC_W-1:0]  rd_vec,
  output logic [PRIO_W-1:0] rd_prio
);
  logic [VEC_W-1:0]  vec_mem  [SLOTS];
  logic [PRIO_W-1:0] prio_mem [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vec_mem[i]  <= '0;
        prio_mem[i] <= '0;
      end else if (push && wr_idx == IDX_W'(i)) begin
        vec_mem[i]  <= wr_vec;
        prio_mem[i] <= wr_prio;
      end
    end
  end

  assign rd_vec  = vec_mem[rd_idx];
  assign rd_prio = prio_mem[rd_idx];

endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import xseq_pkg::*;
#(
  parameter int VEC_W     = 6,
  parameter int PRIO_W    = 4,
  parameter int MAX_NEST  = 8,
  parameter int ENTRY_CYC = 12,
  parameter int EXIT_CYC  = 10,
  parameter int CHAIN_CYC = 6,
  parameter int DEFER_VEC = 14,
  localparam int DEPTH_W  = $clog2(MAX_NEST + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [VEC_W-1:0]   req_vec,
  input  logic [PRIO_W-1:0]  req_prio,
  input  logic               done,
  input  logic               defer_set,
  input  logic               sleep_on_exit,
  output logic [2:0]         phase_o,
  output logic [VEC_W-1:0]   active_vec_o,
  output logic [DEPTH_W-1:0] depth_o,
  output logic               stack_busy_o,
  output logic               nest_ovf_o
);
  localparam int MAXC  = max3(ENTRY_CYC, EXIT_CYC, CHAIN_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int IDX_W = (MAX_NEST > 1) ? $clog2(MAX_NEST) : 1;
  localparam logic [CNT_W-1:0] LD_SAVE    = CNT_W'(span_load(ENTRY_CYC));
  localparam logic [CNT_W-1:0] LD_RESTORE = CNT_W'(span_load(EXIT_CYC));
  localparam logic [CNT_W-1:0] LD_CHAIN   = CNT_W'(span_load(CHAIN_CYC));
  localparam logic [PRIO_W-1:0] PRIO_LOW  = {PRIO_W{1'b1}};
  localparam logic [VEC_W-1:0]  DVEC      = VEC_W'(DEFER_VEC);

  xphase_e phase_q, phase_d;
  logic [VEC_W-1:0]   act_vec_q, act_vec_d, tgt_vec_q, tgt_vec_d;
  logic [PRIO_W-1:0]  act_prio_q, act_prio_d, tgt_prio_q, tgt_prio_d;
  logic               tgt_defer_q, tgt_defer_d;
  logic [DEPTH_W-1:0] depth_q, depth_d;
  logic               defer_q, defer_d;
  logic               ovf_q, ovf_d;

  logic               tmr_load;
  logic [CNT_W-1:0]   tmr_val;
  logic               tmr_zero;

  logic [IDX_W-1:0]   push_idx, pop_idx;
  logic [VEC_W-1:0]   stk_vec;
  logic [PRIO_W-1:0]  stk_prio;

  // Named internal events
  logic in_handler, done_evt, depth_one, nest_full, req_fits_under;
  logic chain_req, chain_defer, go_sleep, go_restore;
  logic preempt_try, preempt_ok, preempt_ovf;
  logic save_replace, save_end, restore_end, chain_end;
  logic idle_take, wake;

  assign in_handler     = (phase_q == PH_HANDLER);
  assign done_evt       = done && in_handler;
  assign depth_one      = (depth_q == DEPTH_W'(1));
  assign nest_full      = (depth_q == DEPTH_W'(MAX_NEST));
  assign req_fits_under = (depth_q <= DEPTH_W'(1)) ||
                          outranks(8'(req_prio), 8'(stk_prio));

  assign chain_req   = done_evt && req_valid && req_fits_under;
  assign chain_defer = done_evt && !chain_req && depth_one && defer_q;
  assign go_sleep    = done_evt && !chain_req && !chain_defer && depth_one && sleep_on_exit;
  assign go_restore  = done_evt && !chain_req && !chain_defer && !go_sleep;

  assign preempt_try = in_handler && !done && req_valid &&
                       outranks(8'(req_prio), 8'(act_prio_q));
  assign preempt_ok  = preempt_try && !nest_full;
  assign preempt_ovf = preempt_try && nest_full;

  assign save_replace = (phase_q == PH_SAVE) && !tmr_zero && req_valid &&
                        outranks(8'(req_prio), 8'(tgt_prio_q));
  assign save_end     = (phase_q == PH_SAVE) && tmr_zero;
  assign restore_end  = (phase_q == PH_RESTORE) && tmr_zero;
  assign chain_end    = (phase_q == PH_CHAIN) && tmr_zero;
  assign idle_take    = (phase_q == PH_IDLE) && (req_valid || defer_q);
  assign wake         = (phase_q == PH_SLEEP) && (req_valid || defer_q);

  assign push_idx = (depth_q >= DEPTH_W'(1)) ? IDX_W'(depth_q - DEPTH_W'(1)) : '0;
  assign pop_idx  = (depth_q >= DEPTH_W'(2)) ? IDX_W'(depth_q - DEPTH_W'(2)) : '0;

  xseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  xseq_ctx_stack #(.VEC_W(VEC_W), .PRIO_W(PRIO_W), .SLOTS(MAX_NEST)) u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (preempt_ok),
    .wr_idx  (push_idx),
    .wr_vec  (act_vec_q),
    .wr_prio (act_prio_q),
    .rd_idx  (pop_idx),
    .rd_vec  (stk_vec),
    .rd_prio (stk_prio)
  );

  always_comb begin
    phase_d     = phase_q;
    act_vec_d   = act_vec_q;
    act_prio_d  = act_prio_q;
    tgt_vec_d   = tgt_vec_q;
    tgt_prio_d  = tgt_prio_q;
    tgt_defer_d = tgt_defer_q;
    depth_d     = depth_q;
    defer_d     = defer_q;
    ovf_d       = ovf_q;
    tmr_load    = 1'b0;
    tmr_val     = '0;

    unique case (phase_q)
      PH_IDLE: begin
        if (idle_take) begin
          phase_d  = PH_SAVE;
          tmr_load = 1'b1;
          tmr_val  = LD_SAVE;
          if (req_valid) begin
            tgt_vec_d = req_vec;  tgt_prio_d = req_prio;  tgt_defer_d = 1'b0;
          end else begin
            tgt_vec_d = DVEC;     tgt_prio_d = PRIO_LOW;  tgt_defer_d = 1'b1;
          end
        end
      end
      PH_SAVE: begin
        if (save_replace) begin
          tgt_vec_d = req_vec;  tgt_prio_d = req_prio;  tgt_defer_d = 1'b0;
        end
        if (save_end) begin
          phase_d    = PH_HANDLER;
          act_vec_d  = tgt_vec_q;
          act_prio_d = tgt_prio_q;
          depth_d    = depth_q + DEPTH_W'(1);
          if (tgt_defer_q) defer_d = 1'b0;
        end
      end
      PH_HANDLER: begin
        if (chain_req) begin
          phase_d  = PH_CHAIN;  tmr_load = 1'b1;  tmr_val = LD_CHAIN;
          tgt_vec_d = req_vec;  tgt_prio_d = req_prio;  tgt_defer_d = 1'b0;
        end else if (chain_defer) begin
          phase_d  = PH_CHAIN;  tmr_load = 1'b1;  tmr_val = LD_CHAIN;
          tgt_vec_d = DVEC;     tgt_prio_d = PRIO_LOW;  tgt_defer_d = 1'b1;
        end else if (go_sleep) begin
          phase_d = PH_SLEEP;
          depth_d = '0;
        end else if (go_restore) begin
          phase_d  = PH_RESTORE;  tmr_load = 1'b1;  tmr_val = LD_RESTORE;
        end else if (preempt_ok) begin
          phase_d  = PH_SAVE;  tmr_load = 1'b1;  tmr_val = LD_SAVE;
          tgt_vec_d = req_vec;  tgt_prio_d = req_prio;  tgt_defer_d = 1'b0;
        end else if (preempt_ovf) begin
          ovf_d = 1'b1;
        end
      end
      PH_RESTORE: begin
        if (restore_end) begin
          if (depth_q > DEPTH_W'(1)) begin
            phase_d    = PH_HANDLER;
            act_vec_d  = stk_vec;
            act_prio_d = stk_prio;
            depth_d    = depth_q - DEPTH_W'(1);
          end else begin
            phase_d = PH_IDLE;
            depth_d = '0;
          end
        end
      end
      PH_CHAIN: begin
        if (chain_end) begin
          phase_d    = PH_HANDLER;
          act_vec_d  = tgt_vec_q;
          act_prio_d = tgt_prio_q;
          if (tgt_defer_q) defer_d = 1'b0;
        end
      end
      PH_SLEEP: begin
        if (wake) begin
          phase_d = PH_HANDLER;
          depth_d = DEPTH_W'(1);
          if (req_valid) begin
            act_vec_d = req_vec;  act_prio_d = req_prio;
          end else begin
            act_vec_d = DVEC;     act_prio_d = PRIO_LOW;  defer_d = 1'b0;
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase

    if (defer_set) defer_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      act_vec_q   <= '0;
      act_prio_q  <= PRIO_LOW;
      tgt_vec_q   <= '0;
      tgt_prio_q  <= PRIO_LOW;
      tgt_defer_q <= 1'b0;
      depth_q     <= '0;
      defer_q     <= 1'b0;
      ovf_q       <= 1'b0;
    end else begin
      phase_q     <= phase_d;
      act_vec_q   <= act_vec_d;
      act_prio_q  <= act_prio_d;
      tgt_vec_q   <= tgt_vec_d;
      tgt_prio_q  <= tgt_prio_d;
      tgt_defer_q <= tgt_defer_d;
      depth_q     <= depth_d;
      defer_q     <= defer_d;
      ovf_q       <= ovf_d;
    end
  end

  assign phase_o      = phase_q;
  assign active_vec_o = act_vec_q;
  assign depth_o      = depth_q;
  assign stack_busy_o = (phase_q == PH_SAVE) || (phase_q == PH_RESTORE);
  assign nest_ovf_o   = ovf_q;

  // R10
  done_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SAVE && !tmr_zero && done) |=> (phase_q == PH_SAVE));

  // R4
  chain_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CHAIN) |=> $stable(depth_q));

  // R12
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

  // R12
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= DEPTH_W'(MAX_NEST));

  // R8
  wake_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SLEEP) |=> (phase_q == PH_SLEEP || phase_q == PH_HANDLER));

  // R6
  nest_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_end && depth_q > DEPTH_W'(1)) |=>
      (phase_q == PH_HANDLER && depth_q == DEPTH_W'($past(depth_q) - DEPTH_W'(1))));

endmodule

// File: tb/exc_seq_bench.sv
module exc_seq_bench;
  localparam int P_IDLE = 0, P_SAVE = 1, P_HAND = 2, P_REST = 3, P_CHAIN = 4, P_SLEEP = 5;
  localparam int SAVE_LEN = 12, REST_LEN = 10, CHAIN_LEN = 6, DEF_VEC = 14, NEST = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [5:0] req_vec = '0;
  logic [3:0] req_prio = '0;
  logic done = 1'b0, defer_set = 1'b0, sleep_on_exit = 1'b0;
  logic [2:0] phase_o;
  logic [5:0] active_vec_o;
  logic [3:0] depth_o;
  logic stack_busy_o, nest_ovf_o;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  exc_seq u_exc_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vec(req_vec),
    .req_prio(req_prio), .done(done), .defer_set(defer_set),
    .sleep_on_exit(sleep_on_exit), .phase_o(phase_o), .active_vec_o(active_vec_o),
    .depth_o(depth_o), .stack_busy_o(stack_busy_o), .nest_ovf_o(nest_ovf_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Offer a request for one cycle; returns at the next negedge.
  task automatic raise(input int v, input int p);
    req_valid = 1'b1; req_vec = 6'(v); req_prio = 4'(p);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse_done();
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  // Count cycles spent in phase ph, optionally pulsing done or a request.
  task automatic measure(input int ph, input int done_at, input int rq_at,
                         input int rv, input int rp, output int n, output int busy_bad);
    n = 0; busy_bad = 0;
    while (int'(phase_o) == ph && n < 200) begin
      if (stack_busy_o != (ph == P_SAVE || ph == P_REST)) busy_bad++;
      done = (n == done_at);
      req_valid = (n == rq_at);
      if (n == rq_at) begin req_vec = 6'(rv); req_prio = 4'(rp); end
      n++;
      @(negedge clk);
    end
    done = 1'b0; req_valid = 1'b0;
  endtask

  task automatic enter(input int v, input int p, input string tag);
    int n, bb;
    raise(v, p);
    measure(P_SAVE, -1, -1, 0, 0, n, bb);
    chk({tag, " save length"}, n, SAVE_LEN);
    chk({tag, " busy during save"}, bb, 0);
    chk({tag, " active vector"}, active_vec_o, v);
  endtask

  task automatic leave(input string tag);
    int n, bb;
    pulse_done();
    measure(P_REST, -1, -1, 0, 0, n, bb);
    chk({tag, " restore length"}, n, REST_LEN);
    chk({tag, " busy during restore"}, bb, 0);
  endtask

  initial begin
    int n, bb;
    do_reset();
    // R1 reset state
    chk("R1 phase", phase_o, P_IDLE);
    chk("R1 depth", depth_o, 0);
    chk("R1 vector", active_vec_o, 0);
    chk("R1 busy", stack_busy_o, 0);
    chk("R1 ovf", nest_ovf_o, 0);

    // R2 / R3 sweep over vectors and priorities
    for (int vi = 0; vi < 4; vi++) begin
      for (int pi = 0; pi < 4; pi++) begin
        enter(vi * 13 + 2, pi * 5, "R2");
        chk("R2 depth", depth_o, 1);
        chk("R2 phase", phase_o, P_HAND);
        leave("R3");
        chk("R3 phase", phase_o, P_IDLE);
        chk("R3 depth", depth_o, 0);
      end
    end

    // R4 chain sweep
    for (int k = 0; k < 4; k++) begin
      enter(3 + k, 7, "R4 first");
      req_valid = 1'b1; req_vec = 6'(30 + k); req_prio = 4'(k * 4);
      done = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; done = 1'b0;
      measure(P_CHAIN, -1, -1, 0, 0, n, bb);
      chk("R4 chain length", n, CHAIN_LEN);
      chk("R4 busy low in chain", bb, 0);
      chk("R4 chained vector", active_vec_o, 30 + k);
      chk("R4 depth", depth_o, 1);
      leave("R4 exit");
    end

    // R10 done outside handler
    pulse_done();
    chk("R10 idle phase", phase_o, P_IDLE);
    @(negedge clk);
    chk("R10 idle still", phase_o, P_IDLE);
    raise(9, 6);
    measure(P_SAVE, 4, -1, 0, 0, n, bb);
    chk("R10 save with done", n, SAVE_LEN);
    pulse_done();
    measure(P_REST, 3, -1, 0, 0, n, bb);
    chk("R10 restore with done", n, REST_LEN);
    chk("R10 back idle", phase_o, P_IDLE);

    // R11 replacement during save
    raise(20, 12);
    measure(P_SAVE, -1, 5, 33, 3, n, bb);
    chk("R11 save not restarted", n, SAVE_LEN);
    chk("R11 replaced vector", active_vec_o, 33);
    leave("R11 exit");
    raise(20, 12);
    measure(P_SAVE, -1, 5, 34, 13, n, bb);
    chk("R11 less urgent kept", active_vec_o, 20);
    leave("R11 exit2");

    // R7 gated chain vs restore
    enter(10, 8, "R7 outer");
    enter(11, 2, "R7 inner");
    chk("R7 depth 2", depth_o, 2);
    req_valid = 1'b1; req_vec = 6'd12; req_prio = 4'd10;
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk("R7 restore chosen", phase_o, P_REST);
    measure(P_REST, -1, 40, 12, 10, n, bb);
    req_valid = 1'b1; req_vec = 6'd12; req_prio = 4'd10;
    chk("R7 back to outer", active_vec_o, 10);
    @(negedge clk);
    chk("R7 no preempt by lower", phase_o, P_HAND);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0; req_valid = 1'b0;
    chk("R7 chain at depth 1", phase_o, P_CHAIN);
    measure(P_CHAIN, -1, -1, 0, 0, n, bb);
    chk("R7 chained vector", active_vec_o, 12);
    leave("R7 exit");

    // R8 sleep on exit
    sleep_on_exit = 1'b1;
    enter(5, 6, "R8 first");
    pulse_done();
    chk("R8 sleep phase", phase_o, P_SLEEP);
    chk("R8 sleep depth", depth_o, 0);
    repeat (3) @(negedge clk);
    chk("R8 stays asleep", phase_o, P_SLEEP);
    raise(7, 4);
    chk("R8 direct handler", phase_o, P_HAND);
    chk("R8 wake vector", active_vec_o, 7);
    chk("R8 wake depth", depth_o, 1);
    sleep_on_exit = 1'b0;
    leave("R8 exit");

    // R9 deferred request
    enter(8, 3, "R9 host");
    defer_set = 1'b1;
    @(negedge clk);
    defer_set = 1'b0;
    chk("R9 no phase change", phase_o, P_HAND);
    @(negedge clk);
    chk("R9 still host", active_vec_o, 8);
    pulse_done();
    chk("R9 chain", phase_o, P_CHAIN);
    measure(P_CHAIN, -1, -1, 0, 0, n, bb);
    chk("R9 chain length", n, CHAIN_LEN);
    chk("R9 deferred vector", active_vec_o, DEF_VEC);
    leave("R9 once only");
    chk("R9 idle", phase_o, P_IDLE);
    defer_set = 1'b1;
    @(negedge clk);
    defer_set = 1'b0;
    chk("R9 not taken at set", phase_o, P_IDLE);
    @(negedge clk);
    measure(P_SAVE, -1, -1, 0, 0, n, bb);
    chk("R9 idle save length", n, SAVE_LEN);
    chk("R9 idle deferred vector", active_vec_o, DEF_VEC);
    leave("R9 idle exit");

    // R5 / R6 / R12 nesting ladder
    enter(41, 15, "R5 level1");
    raise(50, 15);
    chk("R5 equal ignored phase", phase_o, P_HAND);
    chk("R5 equal ignored depth", depth_o, 1);
    for (int lv = 2; lv <= NEST; lv++) begin
      enter(40 + lv, 16 - lv, "R5 preempt");
      chk("R5 depth", depth_o, lv);
    end
    raise(60, 0);
    chk("R12 phase held", phase_o, P_HAND);
    chk("R12 depth held", depth_o, NEST);
    chk("R12 ovf set", nest_ovf_o, 1);
    chk("R12 vector held", active_vec_o, 40 + NEST);
    for (int lv = NEST; lv >= 2; lv--) begin
      leave("R6 unwind");
      chk("R6 vector", active_vec_o, 40 + lv - 1);
      chk("R6 depth", depth_o, lv - 1);
    end
    leave("R6 last");
    chk("R6 idle", phase_o, P_IDLE);
    chk("R12 sticky", nest_ovf_o, 1);

    do_reset();
    chk("R1 ovf cleared", nest_ovf_o, 0);
    chk("R1 phase again", phase_o, P_IDLE);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule